// File: doc/BRIEF.md
# Interrupt and Exception Entry Unit

This unit sits next to a simple processor core and decides when, and to which handler, control is transferred. It arbitrates among three sources:

- exceptions reported by the core while an instruction is executing;
- a software interrupt instruction carrying an 8-bit type number;
- a bank of maskable device request lines.

On accepting a source, it latches a resume program counter and the core's status flags into a single save slot. It then tells the core to clear the interrupt-enable bit and presents the handler's vector-table fetch address on a valid/ready output.

The vector table starts at address zero and holds 4-byte entries, so the fetch address is the type number times four. The resume address depends on the cause:

- A page fault, addressing error or bad opcode saves the faulting PC, so the instruction can be retried or reported.
- An arithmetic overflow, a software interrupt or a device request saves the address of the following instruction.

A return strobe from the core copies the saved PC and flags back, which also restores the earlier enable state.

The redirect output follows valid/ready rules:

- Once `redir_valid` is raised, `redir_addr` holds steady until a cycle in which `redir_ready` is high. The offer is consumed on that edge.
- No new source is accepted while an offer is outstanding, and none on the edge that consumes it.
- A stalled core is expected to keep its exception or software request asserted until the unit takes it.

Top module: `irq_entry_unit`

## Requirements
- R1: After reset, `redir_valid`, `pc_load` and `flags_load` are low, and `saved_pc`, `saved_flags` and `redir_addr` are zero.
- R2: When several sources qualify in the same cycle, an exception wins over a software interrupt, which wins over device requests. Among device lines, the lowest index wins.
- R3: A device request is accepted only in a cycle with `instr_end` high and the interrupt-enable bit (bit 0 of `core_flags`) set. At any other time it causes no redirect.
- R4: An exception is accepted in the cycle `exc_valid` is high, whatever the values of `instr_end` and the enable bit. A software interrupt is likewise accepted regardless of the enable bit.
- R5: The handler type is as follows, and `redir_addr` equals type × 4 with all upper bits zero:
  - an exception has the type of its `exc_code` (0 = overflow, 1 = addressing, 2 = page fault, 3 = bad opcode);
  - a software interrupt has the type `swi_type`;
  - device line i has the type 32 + i.
- R6: On acceptance, `saved_flags` takes `core_flags`, and `saved_pc` is set as follows:
  - it takes `cur_pc` for exception codes 1, 2 and 3;
  - it takes `next_pc` for overflow, software interrupts and device requests.
- R7: The cycle after acceptance, `redir_valid` is high and `flags_load` pulses for one cycle, with `flags_new` equal to `core_flags` with bit 0 cleared.
- R8: While `redir_valid` is high and `redir_ready` is low, `redir_valid` and `redir_addr` stay unchanged, and no source is accepted. The offer drops on the cycle after a ready edge.
- R9: `rti` is honoured only in a cycle with no outstanding offer and no acceptance. It then causes a one-cycle `pc_load` with `pc_new` = `saved_pc`, and `flags_load` with `flags_new` = `saved_flags`. Otherwise it has no effect.
- R10: `saved_pc` and `saved_flags` change only on acceptance. A return leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req | input | N_EXT | Device request lines, level |
| instr_end | input | 1 | Current instruction completes this cycle |
| exc_valid | input | 1 | Core reports an exception this cycle |
| exc_code | input | 2 | Exception cause code |
| swi_valid | input | 1 | Software interrupt instruction completes |
| swi_type | input | 8 | Software interrupt type operand |
| cur_pc | input | PC_W | Address of the executing instruction |
| next_pc | input | PC_W | Address of the following instruction |
| core_flags | input | FLAG_W | Core status flags, bit 0 = interrupt enable |
| rti | input | 1 | Return-from-interrupt strobe |
| redir_valid | output | 1 | Handler fetch address offered |
| redir_ready | input | 1 | Core takes the offered fetch address |
| redir_addr | output | PC_W | Vector table entry address |
| saved_pc | output | PC_W | Saved resume address |
| saved_flags | output | FLAG_W | Saved status flags |
| pc_load | output | 1 | Core must load `pc_new` |
| pc_new | output | PC_W | Program counter to restore |
| flags_load | output | 1 | Core must load `flags_new` |
| flags_new | output | FLAG_W | Status flags to load |

## Verification
Directed patterns are used first:

- A device line held without a boundary, and then with the enable bit clear, separates the boundary check from the mask.
- One cycle in which all three sources fire at once, followed by software-versus-device and two-device cases, shows the priority order and the lowest-index rule.
- A page fault arriving while the ready input holds the redirect low shows both the blocking and the faulting-PC choice. An overflow shows the following-PC choice.
- A return strobe during an outstanding offer, and then a return strobe alone, separate an ignored return from a restore.

A long pseudo-random run then mixes all inputs with random ready stalls, and compares every output each cycle against a behavioural model.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    EXC_OVERFLOW = 2'd0,
    EXC_ADDRESS  = 2'd1,
    EXC_PAGE     = 2'd2,
    EXC_OPCODE   = 2'd3
  } exc_code_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXC  = 2'd1,
    SRC_SWI  = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

  // Overflow resumes past the instruction; the other causes resume at it.
  function automatic logic resumes_after(input exc_code_e c);
    return c == EXC_OVERFLOW;
  endfunction

endpackage

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
#(
  parameter int N_EXT    = 8,
  parameter int TYPE_W   = 8,
  parameter int EXT_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              ie,
  input  logic              instr_end,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic              exc_valid,
  input  logic [1:0]        exc_code,
  input  logic              swi_valid,
  input  logic [TYPE_W-1:0] swi_type,
  output logic              take,
  output src_e              src,
  output logic [TYPE_W-1:0] win_type,
  output logic              use_next
);

  localparam int IDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1;

  logic [N_EXT-1:0] below_free;
  logic [N_EXT-1:0] ext_first;
  logic             ext_hit;
  logic [IDX_W-1:0] ext_idx;

  // Per-line: a line wins among devices if no lower line is requesting.
  genvar g;
  generate
    for (g = 0; g < N_EXT; g++) begin : g_line
      if (g == 0) begin : g_base
        assign below_free[g] = 1'b1;
      end else begin : g_chain
        assign below_free[g] = below_free[g-1] & ~ext_req[g-1];
      end
      assign ext_first[g] = ext_req[g] & below_free[g];
    end
  endgenerate

  always_comb begin
    ext_hit = 1'b0;
    ext_idx = '0;
    for (int i = 0; i < N_EXT; i++) begin
      if (ext_first[i]) begin
        ext_hit = 1'b1;
        ext_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    src      = SRC_NONE;
    win_type = '0;
    use_next = 1'b0;
    if (exc_valid) begin
      src      = SRC_EXC;
      win_type = TYPE_W'(exc_code);
      use_next = resumes_after(exc_code_e'(exc_code));
    end else if (swi_valid) begin
      src      = SRC_SWI;
      win_type = swi_type;
      use_next = 1'b1;
    end else if (ext_hit && instr_end && ie) begin
      src      = SRC_EXT;
      win_type = TYPE_W'(EXT_BASE) + TYPE_W'(ext_idx);
      use_next = 1'b1;
    end
  end

  assign take = !busy && (src != SRC_NONE);

  // R3: a device grant only ever happens at a boundary with enable set
  a_r3_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src == SRC_EXT) |-> (instr_end && ie));

  // R2: the software source never wins over a pending exception
  a_r2_swi_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src == SRC_SWI) |-> !exc_valid);

  // R2: a device grant implies no higher-class source was requesting
  a_r2_ext_last: assert property (@(posedge clk) disable iff (!rst_n)
    (take && src == SRC_EXT) |-> (!exc_valid && !swi_valid));

endmodule

// File: rtl/irq_save_regs.sv
module irq_save_regs #(
  parameter int PC_W   = 32,
  parameter int FLAG_W = 8,
  parameter int IE_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [PC_W-1:0]   resume_pc,
  input  logic [FLAG_W-1:0] core_flags,
  input  logic              rti_fire,
  output logic [PC_W-1:0]   saved_pc,
  output logic [FLAG_W-1:0] saved_flags,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_new,
  output logic              flags_load,
  output logic [FLAG_W-1:0] flags_new
);

  logic [FLAG_W-1:0] ie_mask;

  always_comb begin
    ie_mask         = '1;
    ie_mask[IE_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_pc    <= '0;
      saved_flags <= '0;
      pc_load     <= 1'b0;
      pc_new      <= '0;
      flags_load  <= 1'b0;
      flags_new   <= '0;
    end else begin
      pc_load    <= rti_fire;
      flags_load <= take | rti_fire;
      if (take) begin
        saved_pc    <= resume_pc;
        saved_flags <= core_flags;
        flags_new   <= core_flags & ie_mask;
      end else if (rti_fire) begin
        pc_new    <= saved_pc;
        flags_new <= saved_flags;
      end
    end
  end

  // R7: entry always ends in a flags load with enable cleared
  a_r7_ie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (flags_load && !flags_new[IE_BIT]));

  // R9: a return restores exactly what the save slot held
  a_r9_restore: assert property (@(posedge clk) disable iff (!rst_n)
    rti_fire |=> (pc_load && pc_new == $past(saved_pc)
                  && flags_new == $past(saved_flags)));

  // R10: the save slot only moves on acceptance
  a_r10_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(saved_pc) && $stable(saved_flags)));

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
  import irq_pkg::*;
#(
  parameter int N_EXT    = 8,
  parameter int PC_W     = 32,
  parameter int FLAG_W   = 8,
  parameter int EXT_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_req,
  input  logic              instr_end,
  input  logic              exc_valid,
  input  logic [1:0]        exc_code,
  input  logic              swi_valid,
  input  logic [7:0]        swi_type,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic [PC_W-1:0]   next_pc,
  input  logic [FLAG_W-1:0] core_flags,
  input  logic              rti,
  output logic              redir_valid,
  input  logic              redir_ready,
  output logic [PC_W-1:0]   redir_addr,
  output logic [PC_W-1:0]   saved_pc,
  output logic [FLAG_W-1:0] saved_flags,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_new,
  output logic              flags_load,
  output logic [FLAG_W-1:0] flags_new
);

  localparam int TYPE_W = 8;
  localparam int ENTRY_SHIFT = 2;
  localparam int IE_BIT = 0;

  logic              take;
  src_e              src;
  logic [TYPE_W-1:0] win_type;
  logic              use_next;
  logic [PC_W-1:0]   resume_pc;
  logic [PC_W-1:0]   vec_addr;
  logic              rti_fire;

  irq_select #(
    .N_EXT   (N_EXT),
    .TYPE_W  (TYPE_W),
    .EXT_BASE(EXT_BASE)
  ) u_select (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (redir_valid),
    .ie       (core_flags[IE_BIT]),
    .instr_end(instr_end),
    .ext_req  (ext_req),
    .exc_valid(exc_valid),
    .exc_code (exc_code),
    .swi_valid(swi_valid),
    .swi_type (swi_type),
    .take     (take),
    .src      (src),
    .win_type (win_type),
    .use_next (use_next)
  );

  assign resume_pc = use_next ? next_pc : cur_pc;
  assign rti_fire  = rti && !redir_valid && !take;

  always_comb begin
    vec_addr = '0;
    vec_addr[TYPE_W+ENTRY_SHIFT-1:0] = {win_type, {ENTRY_SHIFT{1'b0}}};
  end

  irq_save_regs #(
    .PC_W  (PC_W),
    .FLAG_W(FLAG_W),
    .IE_BIT(IE_BIT)
  ) u_save (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .resume_pc  (resume_pc),
    .core_flags (core_flags),
    .rti_fire   (rti_fire),
    .saved_pc   (saved_pc),
    .saved_flags(saved_flags),
    .pc_load    (pc_load),
    .pc_new     (pc_new),
    .flags_load (flags_load),
    .flags_new  (flags_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_addr  <= '0;
    end else if (take) begin
      redir_valid <= 1'b1;
      redir_addr  <= vec_addr;
    end else if (redir_valid && redir_ready) begin
      redir_valid <= 1'b0;
    end
  end

  // R8: a stalled offer stays put
  a_r8_offer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_ready) |=> (redir_valid && $stable(redir_addr)));

  // R3: without exception, software request or enabled boundary, no offer appears
  a_r3_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && !exc_valid && !swi_valid
     && !(instr_end && core_flags[IE_BIT])) |=> !redir_valid);

  // R4: an exception with an idle output is taken at once
  a_r4_exc_now: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir_valid && exc_valid) |=> redir_valid);

  // R9: a return during an outstanding offer is dropped
  a_r9_rti_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && rti) |=> !pc_load);

endmodule

// File: tb/test_irq_entry_unit.sv
module test_irq_entry_unit;

  localparam int N_EXT = 8;
  localparam int PC_W = 32;
  localparam int FLAG_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_EXT-1:0]  ext_req = '0;
  logic              instr_end = 1'b0;
  logic              exc_valid = 1'b0;
  logic [1:0]        exc_code = '0;
  logic              swi_valid = 1'b0;
  logic [7:0]        swi_type = '0;
  logic [PC_W-1:0]   cur_pc = '0;
  logic [PC_W-1:0]   next_pc = '0;
  logic [FLAG_W-1:0] core_flags = '0;
  logic              rti = 1'b0;
  logic              redir_ready = 1'b1;
  logic              redir_valid;
  logic [PC_W-1:0]   redir_addr;
  logic [PC_W-1:0]   saved_pc;
  logic [FLAG_W-1:0] saved_flags;
  logic              pc_load;
  logic [PC_W-1:0]   pc_new;
  logic              flags_load;
  logic [FLAG_W-1:0] flags_new;

  always #2.5 clk = ~clk;

  irq_entry_unit i_irq_entry_unit (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .instr_end(instr_end),
    .exc_valid(exc_valid), .exc_code(exc_code), .swi_valid(swi_valid),
    .swi_type(swi_type), .cur_pc(cur_pc), .next_pc(next_pc),
    .core_flags(core_flags), .rti(rti), .redir_valid(redir_valid),
    .redir_ready(redir_ready), .redir_addr(redir_addr), .saved_pc(saved_pc),
    .saved_flags(saved_flags), .pc_load(pc_load), .pc_new(pc_new),
    .flags_load(flags_load), .flags_new(flags_new)
  );

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    running = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit           m_rv, m_fload, m_pload;
  int unsigned  m_addr, m_spc, m_pnew;
  int unsigned  m_sfl, m_fnew;

  always @(posedge clk) begin
    bit          fire;
    int unsigned typ, spc;
    if (!rst_n) begin
      m_rv = 0; m_fload = 0; m_pload = 0;
      m_addr = 0; m_spc = 0; m_pnew = 0; m_sfl = 0; m_fnew = 0;
    end else begin
      fire = 0; typ = 0; spc = 0;
      if (!m_rv) begin
        if (exc_valid) begin
          fire = 1; typ = exc_code;
          spc = (exc_code == 0) ? next_pc : cur_pc;
        end else if (swi_valid) begin
          fire = 1; typ = swi_type; spc = next_pc;
        end else if (instr_end && core_flags[0] && ext_req != 0) begin
          for (int i = N_EXT - 1; i >= 0; i--)
            if (ext_req[i]) typ = 32 + i;
          fire = 1; spc = next_pc;
        end
      end
      if (fire) begin
        m_rv = 1; m_addr = typ * 4; m_spc = spc; m_sfl = core_flags;
        m_fload = 1; m_fnew = core_flags & 8'hFE; m_pload = 0;
      end else if (m_rv) begin
        if (redir_ready) m_rv = 0;
        m_fload = 0; m_pload = 0;
      end else if (rti) begin
        m_pload = 1; m_pnew = m_spc; m_fload = 1; m_fnew = m_sfl;
      end else begin
        m_fload = 0; m_pload = 0;
      end
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk("redir_valid", redir_valid, m_rv);
      chk("redir_addr", redir_addr, m_addr);
      chk("saved_pc", saved_pc, m_spc);
      chk("saved_flags", saved_flags, m_sfl);
      chk("flags_load", flags_load, m_fload);
      chk("pc_load", pc_load, m_pload);
      if (m_fload) chk("flags_new", flags_new, m_fnew);
      if (m_pload) chk("pc_new", pc_new, m_pnew);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    if (m_fload) core_flags = m_fnew[FLAG_W-1:0];
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    running = 1;
    cur_req = "R1";
    chk("reset redir_valid", redir_valid, 0);
    chk("reset saved_pc", saved_pc, 0);
    chk("reset flags_load", flags_load, 0);
    chk("reset pc_load", pc_load, 0);

    core_flags = 8'hA5;
    cur_req = "R3";
    ext_req = 8'h10;
    repeat (3) tick();
    chk("no boundary no entry", redir_valid, 0);

    instr_end = 1; cur_pc = 100; next_pc = 104; redir_ready = 0;
    tick();
    instr_end = 0; ext_req = 0;
    cur_req = "R5"; chk("line4 vector", redir_addr, 144);
    cur_req = "R6"; chk("device resume", saved_pc, 104);
    cur_req = "R7"; chk("ie clear", flags_new, 8'hA4);

    cur_req = "R8";
    exc_valid = 1; exc_code = 2; cur_pc = 200; next_pc = 204;
    repeat (2) tick();
    chk("held addr", redir_addr, 144);
    chk("no overwrite", saved_pc, 104);
    redir_ready = 1;
    tick();
    chk("drop", redir_valid, 0);
    tick();
    exc_valid = 0;
    cur_req = "R4"; chk("masked exc taken", redir_valid, 1);
    cur_req = "R6"; chk("page fault resume", saved_pc, 200);
    cur_req = "R5"; chk("page fault vector", redir_addr, 8);

    cur_req = "R9";
    rti = 1;
    tick();
    chk("rti ignored while pending", pc_load, 0);
    tick();
    rti = 0;
    chk("restore pc", pc_new, 200);
    cur_req = "R10"; chk("slot kept", saved_pc, 200);

    cur_req = "R2";
    core_flags = 8'hA5;
    exc_valid = 1; exc_code = 0; swi_valid = 1; swi_type = 8'h07;
    ext_req = 8'h0C; instr_end = 1; cur_pc = 300; next_pc = 304;
    tick();
    exc_valid = 0; swi_valid = 0; ext_req = 0; instr_end = 0;
    chk("exception first", redir_addr, 0);
    cur_req = "R6"; chk("overflow resume", saved_pc, 304);
    tick();
    rti = 1; tick(); rti = 0;

    cur_req = "R2";
    swi_valid = 1; swi_type = 8'hFF; ext_req = 8'h0C; instr_end = 1;
    tick();
    swi_valid = 0; ext_req = 0; instr_end = 0;
    chk("swi over device", redir_addr, 32'h3FC);
    tick();
    rti = 1; tick(); rti = 0;
    ext_req = 8'h0C; instr_end = 1;
    tick();
    ext_req = 0; instr_end = 0;
    chk("lowest line", redir_addr, 136);

    cur_req = "R3";
    ext_req = 8'h01; instr_end = 1;
    repeat (2) tick();
    chk("masked device", redir_valid, 0);
    ext_req = 0; instr_end = 0;

    cur_req = "R2";
    r = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      exc_valid   = r[0] & r[1] & r[2];
      exc_code    = r[4:3];
      swi_valid   = r[5] & r[6] & r[7];
      swi_type    = r[15:8];
      ext_req     = r[23:16] & r[31:24];
      instr_end   = r[31] | r[0];
      redir_ready = r[12] | r[13];
      rti         = r[20] & r[21];
      cur_pc      = r ^ 32'h00C0_FFEE;
      next_pc     = cur_pc + 4;
      if (r[25:24] == 2'b11) core_flags[0] = 1'b1;
      tick();
    end

    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule